// File: doc/BRIEF.md
# Per-Line Trigger-Mode Interrupt Capture

This block turns a vector of raw interrupt lines into a vector of pending requests. Each line has a 2-bit sensitivity code. The code selects one of four behaviours: the line is pending while high, pending while low, latched on a rising transition, or latched on a falling transition. The codes are packed sixteen to a 32-bit configuration word. Software reads a word, changes one field and writes the word back over a simple register bus.

Lines below 32 have their codes in a local configuration bank at the bottom of the address space. Lines 32 and above are numbered from zero again, in a separate global bank that starts at a configurable byte address. Every raw input passes through a two-flop synchroniser. A per-line detector, steered by that line's code, then updates a pending bit. A per-line completion strobe clears latched edge requests. Priority selection, routing to processors and enable masking are left to the logic downstream.

Top module: `trig_capture`

## Requirements
- R1: After reset every mode field reads as 0, every configuration word reads 0 and the pending vector is all zero.
- R2: The trigger code 0 means pending while the input is high, 1 means pending while the input is low, 2 means latch on a rising transition and 3 means latch on a falling transition.
- R3: Line i below 32 keeps its code in the local bank at byte address ((2*i)/32)*4, bits (2*i) mod 32 upward. Line i at 32 or above keeps its code in the global bank at GLB_BASE (default 0x40) + ((2*(i-32))/32)*4, at bit (2*(i-32)) mod 32.
- R4: A write stores all sixteen fields of the addressed word, and a read returns them. A read-modify-write of one field leaves the other fifteen fields of that word unchanged.
- R5: Addresses outside the configuration words read as 0. Writes to them change no configuration field.
- R6: A change on a raw input reaches the pending output on the third rising clock edge after it is applied, and not earlier.
- R7: In a level mode the pending bit equals the input after the optional inversion. The completion strobe has no lasting effect.
- R8: In an edge mode a qualifying transition sets the pending bit. The bit stays set when the input returns, and only the completion strobe for that line clears it.
- R9: When a qualifying edge and that line's completion strobe arrive in the same cycle, the pending bit ends up set.
- R10: Each line follows only its own code, input and completion strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the configuration word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_in | input | NUM_LINES | Raw interrupt inputs, asynchronous |
| irq_clr | input | NUM_LINES | Per-line completion strobe |
| irq_pend | output | NUM_LINES | Pending requests |

## Verification
The bench moves a field through all four codes on every line with read-modify-write and compares all configuration words after each step. A field offset or bank-base error shows up there as a corrupted neighbouring field or as a code landing in the wrong bank. It measures the input-to-pending latency cycle by cycle, so a missing or extra synchroniser stage is caught. It runs uniform and mixed modes against level and edge patterns. A design that swapped the inversion bit with the edge bit, let a strobe clear a level request, or let edge requests decay when the input returns would produce a wrong pending vector. A clear that collides with a fresh edge is also exercised, which catches a design where clear takes priority.

// File: rtl/trig_capture_pkg.sv
package trig_capture_pkg;

    typedef enum logic [1:0] {
        TRIG_LVL_HI    = 2'd0,
        TRIG_LVL_LO    = 2'd1,
        TRIG_EDGE_RISE = 2'd2,
        TRIG_EDGE_FALL = 2'd3
    } trig_mode_e;

    localparam int FIELD_W      = 2;
    localparam int CFG_WORD_W   = 32;
    localparam int FIELDS_PER_W = CFG_WORD_W / FIELD_W;
    localparam int LOCAL_SPAN   = 32;

    typedef struct packed {
        logic meta;
        logic sync;
        logic hist;
    } sync_chain_t;

    function automatic int bank_index(input int line);
        return (line < LOCAL_SPAN) ? line : line - LOCAL_SPAN;
    endfunction

    function automatic int field_word_off(input int idx);
        return ((idx * FIELD_W) / CFG_WORD_W) * 4;
    endfunction

    function automatic int field_bit_off(input int idx);
        return (idx * FIELD_W) % CFG_WORD_W;
    endfunction

    function automatic logic mode_is_edge(input trig_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_inverts(input trig_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
    import trig_capture_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 8,
    parameter int GLB_BASE  = 'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output trig_mode_e        mode_o [NUM_LINES]
);

    logic [31:0] rd_part [NUM_LINES];

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_field
        localparam int IDX   = bank_index(l);
        localparam int BASE  = (l < LOCAL_SPAN) ? 0 : GLB_BASE;
        localparam int WADDR = BASE + field_word_off(IDX);
        localparam int BOFF  = field_bit_off(IDX);

        logic hit;
        assign hit = (addr == ADDR_W'(WADDR));

        always_ff @(posedge clk) begin
            if (rst) begin
                mode_o[l] <= TRIG_LVL_HI;
            end else if (wr_en && hit) begin
                mode_o[l] <= trig_mode_e'(wr_data[BOFF +: FIELD_W]);
            end
        end

        assign rd_part[l] = hit ? ({30'b0, mode_o[l]} << BOFF) : 32'b0;
    end

    always_comb begin
        rd_data = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            rd_data = rd_data | rd_part[l];
        end
    end

endmodule

// File: rtl/trig_line_detect.sv
module trig_line_detect
    import trig_capture_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       raw,
    input  trig_mode_e mode,
    input  logic       clr,
    output logic       pend
);

    sync_chain_t chain;
    logic        qual_now;
    logic        qual_old;
    logic        hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain.meta <= raw;
            chain.sync <= chain.meta;
            chain.hist <= chain.sync;
        end
    end

    // Polarity folds both edge flavours onto one rising detector.
    assign qual_now = chain.sync ^ mode_inverts(mode);
    assign qual_old = chain.hist ^ mode_inverts(mode);
    assign hit      = qual_now & ~qual_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (mode_is_edge(mode)) begin
            pend <= hit | (pend & ~clr);
        end else begin
            pend <= qual_now;
        end
    end

endmodule

// File: rtl/trig_detect_bank.sv
module trig_detect_bank
    import trig_capture_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] raw,
    input  trig_mode_e           mode [NUM_LINES],
    input  logic [NUM_LINES-1:0] clr,
    output logic [NUM_LINES-1:0] pend
);

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        trig_line_detect u_line (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw[l]),
            .mode (mode[l]),
            .clr  (clr[l]),
            .pend (pend[l])
        );
    end

endmodule

// File: rtl/trig_capture.sv
module trig_capture
    import trig_capture_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 8,
    parameter int GLB_BASE  = 'h40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] irq_clr,
    output logic [NUM_LINES-1:0] irq_pend
);

    trig_mode_e line_mode [NUM_LINES];

    trig_cfg_regs #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .GLB_BASE  (GLB_BASE)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_we),
        .addr    (bus_addr),
        .wr_data (bus_wdata),
        .rd_data (bus_rdata),
        .mode_o  (line_mode)
    );

    trig_detect_bank #(
        .NUM_LINES (NUM_LINES)
    ) u_bank (
        .clk  (clk),
        .rst  (rst),
        .raw  (irq_in),
        .mode (line_mode),
        .clr  (irq_clr),
        .pend (irq_pend)
    );

endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk
    import trig_capture_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] irq_in,
    input logic [NUM_LINES-1:0] irq_clr,
    input logic [NUM_LINES-1:0] irq_pend,
    input logic [31:0]          bus_rdata,
    input trig_mode_e           line_mode [NUM_LINES]
);

    logic [2:0] run_cnt;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (run_cnt != 3'd4) begin
            run_cnt <= run_cnt + 3'd1;
        end
    end
    assign warm = (run_cnt == 3'd4);

    // R1
    reset_pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> irq_pend == '0);

    // R1
    reset_cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> bus_rdata == 32'b0);

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line_chk
        // R7
        level_follow_chk: assert property (@(posedge clk) disable iff (rst)
            (warm && !line_mode[l][1]) |=>
                irq_pend[l] == ($past(irq_in[l], 3) ^ $past(line_mode[l][0])));

        // R8
        edge_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (line_mode[l][1] && irq_pend[l] && !irq_clr[l]) |=> irq_pend[l]);

        // R8
        edge_origin_chk: assert property (@(posedge clk) disable iff (rst)
            (warm && line_mode[l][1] && !irq_pend[l]) |=>
                (!irq_pend[l] ||
                 (($past(irq_in[l], 3) ^ $past(line_mode[l][0])) &&
                  !($past(irq_in[l], 4) ^ $past(line_mode[l][0])))));
    end

endmodule

bind trig_capture trig_capture_chk #(
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .irq_clr   (irq_clr),
    .irq_pend  (irq_pend),
    .bus_rdata (bus_rdata),
    .line_mode (line_mode)
);

// File: tb/trig_capture_tb.sv
module trig_capture_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 64;
    localparam int AW         = 8;
    localparam int GBASE      = 'h40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  irq_in = '0;
    logic [N-1:0]  irq_clr = '0;
    logic [N-1:0]  irq_pend;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] mw [4];
    logic [1:0]  mmode [N];
    logic [N-1:0] mpend;
    logic [N-1:0] mprev;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_capture #(.NUM_LINES(N), .ADDR_W(AW), .GLB_BASE(GBASE)) u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .irq_clr(irq_clr), .irq_pend(irq_pend)
    );

    function automatic logic [AW-1:0] word_addr(input int k);
        return (k < 2) ? AW'(k * 4) : AW'(GBASE + (k - 2) * 4);
    endfunction

    function automatic int word_of(input int line);
        return (line < 32) ? line / 16 : 2 + (line - 32) / 16;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic check_all_words(input string req);
        logic [31:0] d;
        for (int k = 0; k < 4; k++) begin
            bus_read(word_addr(k), d);
            check(req, 64'(d), 64'(mw[k]));
        end
    endtask

    task automatic rebuild_words();
        for (int k = 0; k < 4; k++) mw[k] = '0;
        for (int l = 0; l < N; l++)
            mw[word_of(l)] = mw[word_of(l)] | (32'(mmode[l]) << ((l % 16) * 2));
    endtask

    function automatic logic qual(input int l, input logic v);
        return v ^ mmode[l][0];
    endfunction

    // drive a new input vector, wait out the latency, compare with the model
    task automatic apply(input logic [N-1:0] v, input string req);
        @(negedge clk);
        irq_in = v;
        repeat (3) @(posedge clk);
        #1;
        for (int l = 0; l < N; l++) begin
            if (mmode[l][1]) begin
                if (qual(l, v[l]) && !qual(l, mprev[l])) mpend[l] = 1'b1;
            end else begin
                mpend[l] = qual(l, v[l]);
            end
        end
        mprev = v;
        check(req, irq_pend, mpend);
    endtask

    task automatic pulse_clr(input logic [N-1:0] m, input string req);
        @(negedge clk);
        irq_clr = m;
        @(negedge clk);
        irq_clr = '0;
        for (int l = 0; l < N; l++)
            if (mmode[l][1] && m[l]) mpend[l] = 1'b0;
        #1 check(req, irq_pend, mpend);
    endtask

    task automatic set_modes(input string req);
        rebuild_words();
        for (int k = 0; k < 4; k++) bus_write(word_addr(k), mw[k]);
        repeat (2) @(posedge clk);
        for (int l = 0; l < N; l++)
            if (!mmode[l][1]) mpend[l] = qual(l, mprev[l]);
        pulse_clr('1, req);
    endtask

    initial begin
        logic [31:0] d;
        logic [N-1:0] pat_a;
        logic [N-1:0] pat_b;
        pat_a = 64'hA5C3_0F96_5AF0_3C81;
        pat_b = 64'h0FF0_1234_8421_F00F;
        mpend = '0;
        mprev = '0;
        for (int l = 0; l < N; l++) mmode[l] = 2'd0;
        for (int k = 0; k < 4; k++) mw[k] = '0;

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        check_all_words("R1 words");
        #1 check("R1 pend", irq_pend, '0);

        // R4: full word write and readback
        for (int k = 0; k < 4; k++) begin
            mw[k] = 32'h1357_9BDF ^ (32'h1111_1111 * k);
            bus_write(word_addr(k), mw[k]);
        end
        check_all_words("R4 word readback");
        for (int k = 0; k < 4; k++) mw[k] = '0;
        for (int k = 0; k < 4; k++) bus_write(word_addr(k), 32'h0);

        // R3 R4: read-modify-write sweep of every field through all codes
        for (int l = 0; l < N; l++) begin
            for (int m = 1; m <= 4; m++) begin
                logic [1:0] code;
                int sh;
                code = 2'(m % 4);
                sh = (l % 16) * 2;
                bus_read(word_addr(word_of(l)), d);
                d = (d & ~(32'h3 << sh)) | (32'(code) << sh);
                bus_write(word_addr(word_of(l)), d);
                mw[word_of(l)] = (mw[word_of(l)] & ~(32'h3 << sh)) | (32'(code) << sh);
                if (m == 2 || m == 4) check_all_words("R3 R4 field rmw");
            end
        end

        // R5: unmapped addresses
        mw[0] = 32'hDEAD_BEEF; mw[1] = 32'h0;  mw[2] = 32'h1234_5678; mw[3] = 32'hFFFF_0000;
        for (int k = 0; k < 4; k++) bus_write(word_addr(k), mw[k]);
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_write(8'h3C, 32'hFFFF_FFFF);
        bus_write(8'h48, 32'hFFFF_FFFF);
        bus_write(8'h42, 32'hFFFF_FFFF);
        bus_read(8'h08, d); check("R5 unmapped read", 64'(d), 64'h0);
        bus_read(8'h48, d); check("R5 unmapped read", 64'(d), 64'h0);
        bus_read(8'hFC, d); check("R5 unmapped read", 64'(d), 64'h0);
        check_all_words("R5 writes ignored");

        // R6: latency, all lines active-high level
        for (int l = 0; l < N; l++) mmode[l] = 2'd0;
        set_modes("R2 R7 mode setup");
        @(negedge clk);
        irq_in[5] = 1'b1;
        @(posedge clk); #1 check("R6 edge1", 64'(irq_pend[5]), 64'd0);
        @(posedge clk); #1 check("R6 edge2", 64'(irq_pend[5]), 64'd0);
        @(posedge clk); #1 check("R6 edge3", 64'(irq_pend[5]), 64'd1);
        mprev = irq_in;
        mpend = irq_in;

        // R2 R7: active-high level
        apply(pat_a, "R2 R7 level high");
        apply(~pat_a, "R2 R7 level high");
        pulse_clr('1, "R7 clear ignored");
        apply('0, "R7 level high drop");

        // R2 R7: active-low level
        for (int l = 0; l < N; l++) mmode[l] = 2'd1;
        set_modes("R2 mode low");
        check("R2 low idle", irq_pend, '1);
        apply(pat_b, "R2 R7 level low");
        pulse_clr('1, "R7 clear ignored low");
        apply('1, "R2 R7 level low");

        // R2 R8: rising edge
        apply('0, "R8 prep");
        for (int l = 0; l < N; l++) mmode[l] = 2'd2;
        set_modes("R8 mode rise");
        check("R8 rise idle", irq_pend, '0);
        apply(pat_a, "R2 R8 rise set");
        apply('0, "R8 sticky after drop");
        pulse_clr(pat_b, "R8 partial clear");
        apply(pat_b, "R2 R8 rise again");
        pulse_clr('1, "R8 full clear");

        // R2 R8: falling edge
        for (int l = 0; l < N; l++) mmode[l] = 2'd3;
        set_modes("R8 mode fall");
        apply('1, "R2 R8 fall none");
        apply(~pat_b, "R2 R8 fall set");
        apply('1, "R8 fall sticky");
        pulse_clr('1, "R8 fall clear");

        // R10: mixed modes per line
        apply('0, "R10 prep");
        for (int l = 0; l < N; l++) mmode[l] = 2'(l % 4);
        set_modes("R10 mixed setup");
        apply(pat_a, "R10 mixed");
        apply(pat_b, "R10 mixed");
        pulse_clr(pat_a, "R10 mixed clear");
        apply(~pat_a, "R10 mixed");
        apply('0, "R10 mixed");
        pulse_clr('1, "R10 mixed clear all");

        // R9: edge and clear collide on line 2 (rising mode)
        apply(64'h4, "R9 prep set");
        apply(64'h0, "R9 prep drop");
        check("R9 pre pending", 64'(irq_pend[2]), 64'd1);
        @(negedge clk);
        irq_in[2] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        irq_clr[2] = 1'b1;
        @(negedge clk);
        irq_clr[2] = 1'b0;
        #1 check("R9 set wins", 64'(irq_pend[2]), 64'd1);
        mprev = irq_in;
        pulse_clr(64'h4, "R9 later clear");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule